// File: doc/BRIEF.md
# Sector Buffer Transfer Engine

This block drains decoded sector data out of a byte-organised buffer. A transfer is armed with a byte count and a buffer data address. It is then emptied in one of two ways. A processor can pull 16-bit words one at a time through a host read port. Alternatively, a DMA step copies a burst of words into a destination RAM. Both paths share the byte count, which decides when the transfer ends. When it ends, the engine updates its status flags and may raise a level-5 interrupt request.

The buffer is read through a two-byte synchronous port. For a presented address A, the data arrives one cycle later: the byte at A on the high lane and the byte at A+1 (mod 65536) on the low lane. The destination is a synchronous write port addressed in bytes. A destination pointer is loaded from outside. The byte offset of the first word is derived from this pointer in a way that depends on the target memory. After every DMA step the pointer is advanced by an amount that also depends on the target. A DMA step moves one word per clock and holds `busy_o` high until its last write has been issued.

Top module: `sector_xfer_engine`

## Requirements
- R1: After reset the engine is inactive. The end flag, data-ready flag, busy, irq5_o, count_o, addr_o and ptr_o are all 0. The interface-idle flag and the active-low transfer-end flag dte_n_o are 1.
- R2: A host read is honoured only when all of these hold: the transfer is active, no DMA step is busy, and dest_code_i equals 3 for a sub-CPU requester (hrd_sub_i=1) or 2 for a main-CPU requester (hrd_sub_i=0). A read that is not honoured returns hrd_data_o=0 in the next cycle and leaves count, address and flags unchanged.
- R3: An honoured host read returns, in the following cycle, the buffer byte at the data address as bits 15:8 and the next byte (address+1, mod 65536) as bits 7:0. It adds 2 to the data address and subtracts 2 from the byte count.
- R4: If the byte count is 2 or less when an honoured host read occurs, the count becomes 0 and the transfer ends.
- R5: Ending a transfer clears active and data-ready and sets the end flag and the interface-idle flag. If dte_ie_i is 1, it also clears dte_n_o. If dte_ie_i and irq_mask5_i are both 1, irq5_o pulses for one cycle together with the end.
- R6: A DMA step (dma_go_i while active and not busy) moves 256 words and lowers the count by 512 when the count exceeds 512. Otherwise it moves (count+1)/2 words, sets the count to 0 and ends the transfer at the start of the step.
- R7: A step of W words keeps busy_o high for W+1 cycles (none when W=0) and ignores dma_go_i while busy. It advances the data address by 2W modulo 65536, and the writes carry the buffer words in address order.
- R8: For tgt_i=0 (program RAM), the first destination byte offset is ptr<<3. For tgt_i=1 with wram_1m_i=0, it is ptr[14:0]<<3. In both cases each further word is written 2 bytes higher.
- R9: For tgt_i=1 with wram_1m_i=1, the first offset is (ptr[13:0]<<4) plus 2 when bank_sel_i=0, and each further word is written 4 bytes higher.
- R10: After a step of W words the destination pointer grows by W/4 (integer) for tgt_i 0 or 1, and by W/2 for tgt_i 2 or 3. Targets 2 and 3 produce no destination writes.
- R11: start_i (when not busy) loads the count and data address, sets active and data-ready, and clears the end flag and the interface-idle flag. dte_ack_i sets dte_n_o back to 1. ptr_ld_i loads the pointer while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Arm a transfer |
| start_count_i | input | 16 | Byte count loaded by start_i |
| start_addr_i | input | 16 | Buffer data address loaded by start_i |
| dte_ie_i | input | 1 | Transfer-end interrupt enable |
| irq_mask5_i | input | 1 | Level-5 interrupt mask bit |
| dte_ack_i | input | 1 | Re-arm the active-low transfer-end flag |
| hrd_req_i | input | 1 | Host word read request |
| hrd_sub_i | input | 1 | Requester is the sub-CPU |
| dest_code_i | input | 3 | Destination-select code |
| hrd_data_o | output | 16 | Host read data, one cycle after the request |
| ptr_ld_i | input | 1 | Load destination pointer |
| ptr_val_i | input | 16 | Destination pointer value |
| tgt_i | input | 2 | DMA target: 0 program RAM, 1 word RAM, 2/3 PCM |
| wram_1m_i | input | 1 | Word RAM split (1M) layout |
| bank_sel_i | input | 1 | Word RAM bank select in 1M layout |
| dma_go_i | input | 1 | Request one DMA step |
| busy_o | output | 1 | DMA step in progress |
| buf_addr_o | output | 16 | Buffer read address |
| buf_hi_i | input | 8 | Buffer byte at address |
| buf_lo_i | input | 8 | Buffer byte at address+1 |
| dst_we_o | output | 1 | Destination write strobe |
| dst_addr_o | output | 20 | Destination byte offset |
| dst_wdata_o | output | 16 | Destination write word |
| count_o | output | 16 | Remaining byte count |
| addr_o | output | 16 | Buffer data address |
| ptr_o | output | 16 | Destination pointer |
| active_o | output | 1 | Transfer active |
| end_o | output | 1 | Transfer-end status flag |
| rdy_o | output | 1 | Data-ready status flag |
| if_idle_o | output | 1 | Interface idle (no transfer running) |
| dte_n_o | output | 1 | Active-low transfer-end interrupt flag |
| irq5_o | output | 1 | Level-5 interrupt request pulse |

## Verification
Host reads are tried with every combination of requester and destination code. This separates the two accepted pairings from mismatched and inactive requests. Counts of 0, 1, 2, 512, 513 and large random values, together with data addresses near 0xFFFF, distinguish the full-burst path from the last-step path and expose wrap errors in the address and in the paired byte. DMA steps are run for every target, both word RAM layouts and both bank values, with random pointers. This tells apart the base-offset formulas, the 2 and 4 byte strides and the two pointer scalings. A second dma_go_i raised mid-step shows whether a busy step can be restarted.

// File: rtl/sxe_pkg.sv
package sxe_pkg;
    localparam logic [2:0] DEST_MAIN = 3'd2;
    localparam logic [2:0] DEST_SUB  = 3'd3;

    localparam logic [1:0] TGT_PRG  = 2'd0;
    localparam logic [1:0] TGT_WRAM = 2'd1;
endpackage

// File: rtl/sxe_host_gate.sv
module sxe_host_gate #(
    parameter int CW = 16
) (
    input  logic          req,
    input  logic          is_sub,
    input  logic [2:0]    code,
    input  logic          active,
    input  logic          busy,
    input  logic          start,
    input  logic [CW-1:0] count,
    output logic          ok,
    output logic          last,
    output logic [CW-1:0] count_nx
);
    import sxe_pkg::*;

    logic match;

    always_comb begin
        match    = is_sub ? (code == DEST_SUB) : (code == DEST_MAIN);
        ok       = req && active && !busy && !start && match;
        last     = (count <= CW'(2));
        count_nx = last ? '0 : count - CW'(2);
    end
endmodule

// File: rtl/sxe_burst_plan.sv
module sxe_burst_plan #(
    parameter int CW    = 16,
    parameter int BURST = 256,
    parameter int WW    = 9
) (
    input  logic [CW-1:0] count,
    output logic [WW-1:0] words,
    output logic          last,
    output logic [CW-1:0] count_nx
);
    localparam int LIMIT = 2 * BURST;

    logic [CW:0] rounded;

    always_comb begin
        rounded  = ({1'b0, count} + (CW+1)'(1)) >> 1;
        last     = (count <= CW'(LIMIT));
        words    = last ? WW'(rounded) : WW'(BURST);
        count_nx = last ? '0 : count - CW'(LIMIT);
    end
endmodule

// File: rtl/sxe_dest_map.sv
module sxe_dest_map #(
    parameter int PW = 16,
    parameter int OW = 20,
    parameter int WW = 9
) (
    input  logic [1:0]    tgt,
    input  logic          split_1m,
    input  logic          bank,
    input  logic [PW-1:0] ptr,
    input  logic [WW-1:0] words,
    output logic [OW-1:0] base,
    output logic [2:0]    stride,
    output logic          no_write,
    output logic [PW-1:0] ptr_nx
);
    import sxe_pkg::*;

    logic pcm;

    always_comb begin
        pcm      = tgt[1];
        no_write = pcm;
        ptr_nx   = ptr + (pcm ? PW'(words >> 1) : PW'(words >> 2));
        stride   = 3'd2;
        base     = OW'({ptr, 3'b000});
        if (tgt == TGT_WRAM) begin
            if (split_1m) begin
                stride = 3'd4;
                base   = OW'({ptr[13:0], 4'b0000}) + (bank ? OW'(0) : OW'(2));
            end else begin
                base   = OW'({ptr[14:0], 3'b000});
            end
        end
    end
endmodule

// File: rtl/sector_xfer_engine.sv
module sector_xfer_engine #(
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int PW    = 16,
    parameter int OW    = 20,
    parameter int BURST = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] start_count_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic          dte_ie_i,
    input  logic          irq_mask5_i,
    input  logic          dte_ack_i,
    input  logic          hrd_req_i,
    input  logic          hrd_sub_i,
    input  logic [2:0]    dest_code_i,
    output logic [15:0]   hrd_data_o,
    input  logic          ptr_ld_i,
    input  logic [PW-1:0] ptr_val_i,
    input  logic [1:0]    tgt_i,
    input  logic          wram_1m_i,
    input  logic          bank_sel_i,
    input  logic          dma_go_i,
    output logic          busy_o,
    output logic [AW-1:0] buf_addr_o,
    input  logic [7:0]    buf_hi_i,
    input  logic [7:0]    buf_lo_i,
    output logic          dst_we_o,
    output logic [OW-1:0] dst_addr_o,
    output logic [15:0]   dst_wdata_o,
    output logic [CW-1:0] count_o,
    output logic [AW-1:0] addr_o,
    output logic [PW-1:0] ptr_o,
    output logic          active_o,
    output logic          end_o,
    output logic          rdy_o,
    output logic          if_idle_o,
    output logic          dte_n_o,
    output logic          irq5_o
);
    localparam int WW = $clog2(BURST) + 1;

    typedef struct packed {
        logic [CW-1:0] count;
        logic [AW-1:0] addr;
        logic [PW-1:0] ptr;
        logic          active;
        logic          endf;
        logic          rdy;
        logic          idle;
        logic          dte_n;
        logic          irq;
        logic          hvalid;
        logic          busy;
        logic [WW-1:0] left;
        logic          wpend;
        logic [OW-1:0] off;
        logic [2:0]    stride;
        logic          nowr;
    } st_t;

    st_t s_d, s_q;

    logic          h_ok, h_last;
    logic [CW-1:0] h_count;
    logic [WW-1:0] b_words;
    logic          b_last;
    logic [CW-1:0] b_count;
    logic [OW-1:0] m_base;
    logic [2:0]    m_stride;
    logic          m_nowr;
    logic [PW-1:0] m_ptr;
    logic          do_end;
    logic          we_d;

    sxe_host_gate #(.CW(CW)) u_gate (
        .req(hrd_req_i), .is_sub(hrd_sub_i), .code(dest_code_i),
        .active(s_q.active), .busy(s_q.busy), .start(start_i),
        .count(s_q.count), .ok(h_ok), .last(h_last), .count_nx(h_count)
    );

    sxe_burst_plan #(.CW(CW), .BURST(BURST), .WW(WW)) u_plan (
        .count(s_q.count), .words(b_words), .last(b_last), .count_nx(b_count)
    );

    sxe_dest_map #(.PW(PW), .OW(OW), .WW(WW)) u_map (
        .tgt(tgt_i), .split_1m(wram_1m_i), .bank(bank_sel_i), .ptr(s_q.ptr),
        .words(b_words), .base(m_base), .stride(m_stride), .no_write(m_nowr),
        .ptr_nx(m_ptr)
    );

    always_comb begin
        s_d        = s_q;
        s_d.irq    = 1'b0;
        s_d.hvalid = 1'b0;
        do_end     = 1'b0;
        we_d       = 1'b0;

        if (dte_ack_i) s_d.dte_n = 1'b1;

        if (s_q.busy) begin
            if (s_q.left != '0) begin
                s_d.addr  = s_q.addr + AW'(2);
                s_d.left  = s_q.left - WW'(1);
                s_d.wpend = 1'b1;
            end else begin
                s_d.wpend = 1'b0;
            end
            if (s_q.wpend) begin
                we_d    = !s_q.nowr;
                s_d.off = s_q.off + OW'(s_q.stride);
            end
            s_d.busy = (s_d.left != '0) || s_d.wpend;
        end else if (start_i) begin
            s_d.count  = start_count_i;
            s_d.addr   = start_addr_i;
            s_d.active = 1'b1;
            s_d.rdy    = 1'b1;
            s_d.endf   = 1'b0;
            s_d.idle   = 1'b0;
        end else if (h_ok) begin
            s_d.count  = h_count;
            s_d.addr   = s_q.addr + AW'(2);
            s_d.hvalid = 1'b1;
            do_end     = h_last;
        end else if (dma_go_i && s_q.active) begin
            s_d.count  = b_count;
            s_d.ptr    = m_ptr;
            s_d.off    = m_base;
            s_d.stride = m_stride;
            s_d.nowr   = m_nowr;
            s_d.left   = b_words;
            s_d.wpend  = 1'b0;
            s_d.busy   = (b_words != '0);
            do_end     = b_last;
        end else if (ptr_ld_i) begin
            s_d.ptr = ptr_val_i;
        end

        if (do_end) begin
            s_d.active = 1'b0;
            s_d.rdy    = 1'b0;
            s_d.endf   = 1'b1;
            s_d.idle   = 1'b1;
            if (dte_ie_i) begin
                s_d.dte_n = 1'b0;
                s_d.irq   = irq_mask5_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.idle  <= 1'b1;
            s_q.dte_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign hrd_data_o  = s_q.hvalid ? {buf_hi_i, buf_lo_i} : 16'h0000;
    assign buf_addr_o  = s_q.addr;
    assign dst_we_o    = we_d;
    assign dst_addr_o  = s_q.off;
    assign dst_wdata_o = {buf_hi_i, buf_lo_i};
    assign busy_o      = s_q.busy;
    assign count_o     = s_q.count;
    assign addr_o      = s_q.addr;
    assign ptr_o       = s_q.ptr;
    assign active_o    = s_q.active;
    assign end_o       = s_q.endf;
    assign rdy_o       = s_q.rdy;
    assign if_idle_o   = s_q.idle;
    assign dte_n_o     = s_q.dte_n;
    assign irq5_o      = s_q.irq;

    // R2: a quiet cycle with no honourable read leaves the counters alone
    p_quiet_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i && !dma_go_i && !ptr_ld_i &&
         !(hrd_req_i && active_o &&
           ((hrd_sub_i && dest_code_i == 3'd3) || (!hrd_sub_i && dest_code_i == 3'd2))))
        |=> ($stable(count_o) && $stable(addr_o) && $stable(ptr_o)));

    // R2: an inactive engine never hands out data
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hrd_req_i && !active_o) |=> (hrd_data_o == 16'h0000));

    // R4 / R5: the end of a transfer leaves the count empty and the flags settled
    p_end_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_o) |-> (count_o == '0 && end_o && if_idle_o && !rdy_o));

    // R5: the interrupt pulse only accompanies an enabled, unmasked end
    p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq5_o |-> ($past(dte_ie_i && irq_mask5_i) && $fell(active_o)));

    // R7: destination writes happen only inside a step
    p_we_in_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we_o |-> busy_o);

    // R7: a go request during a step does not move the pointer
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && dma_go_i) |=> $stable(ptr_o));

    // R8 / R9: consecutive writes climb by the latched stride
    p_stride_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we_o && $past(dst_we_o)) |-> (dst_addr_o == $past(dst_addr_o) + OW'(s_q.stride)));

    // R10: a PCM step never strobes the destination
    p_pcm_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && s_q.nowr) |-> !dst_we_o);
endmodule

// File: tb/sim_sector_xfer_engine.sv
module sim_sector_xfer_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] start_count_i = '0;
    logic [15:0] start_addr_i = '0;
    logic        dte_ie_i = 1'b0;
    logic        irq_mask5_i = 1'b0;
    logic        dte_ack_i = 1'b0;
    logic        hrd_req_i = 1'b0;
    logic        hrd_sub_i = 1'b0;
    logic [2:0]  dest_code_i = '0;
    logic [15:0] hrd_data_o;
    logic        ptr_ld_i = 1'b0;
    logic [15:0] ptr_val_i = '0;
    logic [1:0]  tgt_i = '0;
    logic        wram_1m_i = 1'b0;
    logic        bank_sel_i = 1'b0;
    logic        dma_go_i = 1'b0;
    logic        busy_o;
    logic [15:0] buf_addr_o;
    logic [7:0]  buf_hi_i, buf_lo_i;
    logic        dst_we_o;
    logic [19:0] dst_addr_o;
    logic [15:0] dst_wdata_o;
    logic [15:0] count_o, addr_o, ptr_o;
    logic        active_o, end_o, rdy_o, if_idle_o, dte_n_o, irq5_o;

    int n_chk = 0;
    int n_err = 0;

    logic [15:0] m_count = '0, m_addr = '0, m_ptr = '0;
    logic        m_active = 1'b0, m_end = 1'b0, m_rdy = 1'b0, m_idle = 1'b1, m_dten = 1'b1;

    logic [19:0] wa [0:511];
    logic [15:0] wd [0:511];
    int wn = 0;

    always #4 clk = ~clk;

    sector_xfer_engine u0 (.*);

    function automatic logic [7:0] bb(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    always_ff @(posedge clk) begin
        buf_hi_i <= bb(buf_addr_o);
        buf_lo_i <= bb(buf_addr_o + 16'd1);
    end

    always @(negedge clk) begin
        if (dst_we_o) begin
            if (wn < 512) begin
                wa[wn] = dst_addr_o;
                wd[wn] = dst_wdata_o;
            end
            wn = wn + 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_flags(input string req);
        chk(req, "active", 32'(active_o), 32'(m_active));
        chk(req, "end flag", 32'(end_o), 32'(m_end));
        chk(req, "ready flag", 32'(rdy_o), 32'(m_rdy));
        chk(req, "idle flag", 32'(if_idle_o), 32'(m_idle));
        chk(req, "dte_n", 32'(dte_n_o), 32'(m_dten));
        chk(req, "count", 32'(count_o), 32'(m_count));
        chk(req, "addr", 32'(addr_o), 32'(m_addr));
        chk(req, "ptr", 32'(ptr_o), 32'(m_ptr));
    endtask

    task automatic model_end();
        m_active = 1'b0; m_rdy = 1'b0; m_end = 1'b1; m_idle = 1'b1;
        if (dte_ie_i) m_dten = 1'b0;
    endtask

    task automatic do_start(input logic [15:0] c, input logic [15:0] a);
        @(negedge clk);
        start_i = 1'b1; start_count_i = c; start_addr_i = a;
        @(negedge clk);
        start_i = 1'b0;
        m_count = c; m_addr = a; m_active = 1'b1; m_rdy = 1'b1; m_end = 1'b0; m_idle = 1'b0;
        chk_flags("R11");
    endtask

    task automatic load_ptr(input logic [15:0] p);
        @(negedge clk);
        ptr_ld_i = 1'b1; ptr_val_i = p;
        @(negedge clk);
        ptr_ld_i = 1'b0;
        m_ptr = p;
        chk("R11", "ptr load", 32'(ptr_o), 32'(p));
    endtask

    task automatic ack();
        @(negedge clk);
        dte_ack_i = 1'b1;
        @(negedge clk);
        dte_ack_i = 1'b0;
        m_dten = 1'b1;
        chk("R11", "dte_n after ack", 32'(dte_n_o), 32'd1);
    endtask

    task automatic host_read(input logic sub, input logic [2:0] code);
        bit ok, last;
        logic [15:0] exp_d;
        ok = m_active && (sub ? (code == 3'd3) : (code == 3'd2));
        exp_d = ok ? {bb(m_addr), bb(m_addr + 16'd1)} : 16'h0000;
        last = 1'b0;
        @(negedge clk);
        hrd_req_i = 1'b1; hrd_sub_i = sub; dest_code_i = code;
        @(negedge clk);
        hrd_req_i = 1'b0;
        if (ok) begin
            last = (m_count <= 16'd2);
            m_count = last ? 16'd0 : m_count - 16'd2;
            m_addr = m_addr + 16'd2;
            if (last) model_end();
        end
        chk(ok ? "R3" : "R2", "host data", 32'(hrd_data_o), 32'(exp_d));
        chk(last ? "R4" : "R2", "count after read", 32'(count_o), 32'(m_count));
        chk("R3", "addr after read", 32'(addr_o), 32'(m_addr));
        chk("R5", "irq after read", 32'(irq5_o), 32'(last && dte_ie_i && irq_mask5_i));
        chk_flags("R5");
    endtask

    task automatic dma_step(input logic [1:0] tgt, input logic m1, input logic bk, input bit poke);
        int w, stride, nb, bad;
        bit last, pcm;
        logic [19:0] base, ea;
        logic [15:0] a0, ed, ptr0;
        string rq;
        if (!m_active) return;
        last = (m_count <= 16'd512);
        w = last ? (int'(m_count) + 1) / 2 : 256;
        pcm = tgt[1];
        ptr0 = m_ptr;
        stride = 2;
        base = {1'b0, ptr0, 3'b000};
        rq = "R8";
        if (tgt == 2'd1) begin
            if (m1) begin
                stride = 4; rq = "R9";
                base = {2'b00, ptr0[13:0], 4'b0000} + (bk ? 20'd0 : 20'd2);
            end else begin
                base = {2'b00, ptr0[14:0], 3'b000};
            end
        end
        if (pcm) rq = "R10";
        a0 = m_addr;
        @(negedge clk);
        tgt_i = tgt; wram_1m_i = m1; bank_sel_i = bk; dma_go_i = 1'b1; wn = 0;
        @(negedge clk);
        dma_go_i = 1'b0;
        m_count = last ? 16'd0 : m_count - 16'd512;
        m_ptr = ptr0 + (pcm ? 16'(w / 2) : 16'(w / 4));
        if (last) model_end();
        chk("R5", "irq at step", 32'(irq5_o), 32'(last && dte_ie_i && irq_mask5_i));
        nb = 0;
        while (busy_o) begin
            nb++;
            if (poke && nb == 2) dma_go_i = 1'b1;
            @(negedge clk);
            dma_go_i = 1'b0;
        end
        m_addr = a0 + 16'(2 * w);
        chk("R7", "busy cycles", 32'(nb), 32'(w == 0 ? 0 : w + 1));
        chk("R6", "count after step", 32'(count_o), 32'(m_count));
        chk("R7", "addr after step", 32'(addr_o), 32'(m_addr));
        chk("R10", "ptr after step", 32'(ptr_o), 32'(m_ptr));
        chk(rq, "write count", 32'(wn), 32'(pcm ? 0 : w));
        bad = -1;
        if (!pcm) begin
            for (int k = 0; k < w && k < wn; k++) begin
                ea = base + 20'(stride * k);
                ed = {bb(a0 + 16'(2 * k)), bb(a0 + 16'(2 * k + 1))};
                if (bad < 0 && (wa[k] !== ea || wd[k] !== ed)) bad = k;
            end
        end
        if (bad < 0) chk(rq, "write stream", 32'd0, 32'd0);
        else chk(rq, "write stream addr/data",
                 {wa[bad][15:0], wd[bad]},
                 {16'(base + 20'(stride * bad)), bb(a0 + 16'(2 * bad)), bb(a0 + 16'(2 * bad + 1))});
        chk_flags("R6");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy at reset", 32'(busy_o), 32'd0);
        chk("R1", "irq at reset", 32'(irq5_o), 32'd0);
        chk_flags("R1");

        host_read(1'b1, 3'd3);

        dte_ie_i = 1'b1; irq_mask5_i = 1'b1;
        do_start(16'd6, 16'h0010);
        host_read(1'b0, 3'd3);
        host_read(1'b1, 3'd2);
        host_read(1'b1, 3'd3);
        host_read(1'b0, 3'd2);
        host_read(1'b1, 3'd3);
        host_read(1'b1, 3'd3);
        ack();

        irq_mask5_i = 1'b0;
        do_start(16'd1, 16'hFFFF);
        host_read(1'b0, 3'd2);
        ack();

        dte_ie_i = 1'b0;
        do_start(16'd0, 16'h0200);
        dma_step(2'd0, 1'b0, 1'b0, 1'b0);

        dte_ie_i = 1'b1; irq_mask5_i = 1'b1;
        load_ptr(16'hFFFF);
        do_start(16'd1201, 16'hFF00);
        dma_step(2'd0, 1'b0, 1'b0, 1'b1);
        dma_step(2'd1, 1'b0, 1'b0, 1'b0);
        dma_step(2'd1, 1'b1, 1'b0, 1'b0);
        ack();

        load_ptr(16'h4321);
        do_start(16'd513, 16'h1234);
        dma_step(2'd1, 1'b1, 1'b1, 1'b0);
        dma_step(2'd2, 1'b0, 1'b0, 1'b0);
        do_start(16'd512, 16'h0000);
        dma_step(2'd3, 1'b0, 1'b0, 1'b0);
        do_start(16'd512, 16'h8000);
        dma_step(2'd1, 1'b1, 1'b0, 1'b0);

        for (int it = 0; it < 24; it++) begin
            dte_ie_i = 1'($urandom_range(0, 1));
            irq_mask5_i = 1'($urandom_range(0, 1));
            if (!m_dten) ack();
            load_ptr(16'($urandom));
            do_start(16'($urandom_range(0, 1400)), 16'($urandom));
            for (int h = 0; h < 4; h++)
                host_read(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)));
            for (int s = 0; s < 5 && m_active; s++)
                dma_step(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                         1'($urandom_range(0, 1)), 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule